// File: doc/BRIEF.md
# Two-Phase PWM Channel with Tick Prescaler

This block drives one pulse-width-modulated output. The waveform is not set by a period value and a duty value. Software writes one data word that holds two separate tick counts, each stored minus one: the length of the active phase and the length of the rest phase. The output stays active for the first count and inactive for the second. This repeats for as long as the channel is enabled.

A divide-by-(N+1) prescaler sits in front of the phase counters. The prescaler can count every core clock, or only the cycles on which an external strobe input `ext_tick` is high. A control word holds the run bit, an output-inversion bit and that source-select bit. New data or divider values wait in shadow registers. They move into the working copies only when a rest phase ends, so a period that is under way is never cut short or stretched.

Control is a three-state machine. In the `PH_IDLE` state the counters are cleared and the output sits at its inactive level. The `PH_ACTIVE` state is the active phase and the `PH_REST` state is the inactive phase. It has these transitions:
- run bit set moves `PH_IDLE` to `PH_ACTIVE`, loading the working copies;
- final tick of the active count moves `PH_ACTIVE` to `PH_REST`;
- final tick of the rest count moves `PH_REST` to `PH_ACTIVE`, loading the shadows;
- run bit clear moves any state to `PH_IDLE`.

Top module: `pwm_dual_count`

## Requirements
- R1: After reset all registers are zero, the channel is disabled, and `pwm_out` is 0.
- R2: `wr_sel`=2 writes the data word. Bits [2*TICK_BITS-1:TICK_BITS] hold the active count minus one (A) and bits [TICK_BITS-1:0] hold the rest count minus one (B). With divider N the output is active for (N+1)*(A+1) clocks and inactive for (N+1)*(B+1) clocks, repeating.
- R3: `wr_sel`=1 writes the divider. N is taken from bits [DIV_BITS:1], and bit 0 has no effect on timing.
- R4: An encoded count of 0 gives a phase of exactly one tick, so A=B=N=0 produces a 2-clock period.
- R5: `wr_sel`=0 writes the control word, and bit 0 is the run bit. When bit 0 is cleared, the machine returns to `PH_IDLE` on the next clock and `pwm_out` stays at its inactive level.
- R6: Control bit 1 inverts the output in every state, including idle. With it set, the output is low for the active count and high for the rest count.
- R7: With control bit 2 set, the prescaler advances only on clocks where `ext_tick` is 1. With ext_tick pulsing once every 4 clocks, N=0, A=1 and B=2, the output is high for 8 clocks and low for 12.
- R8: A data or divider write made during a period changes nothing until the current rest phase ends. The next period uses the new values.
- R9: The first active phase starts on the clock after the run bit is written: `pwm_out` rises one clock after the control write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 divider, 2 data |
| wr_data | input | REG_W | Write data |
| ext_tick | input | 1 | External tick strobe, used when control bit 2 is set |
| pwm_out | output | 1 | PWM output after the inverter |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a period. It only shows if the write falls inside an active phase and the bench then measures both the rest of that period and the one that follows. The bench locks onto a rising edge of the output and issues a data write a few clocks into the active phase from a parallel thread. It then measures four phase lengths in a row: the first two must keep the old counts and the next two must take the new ones. The external-strobe mode is measured only after a whole period has gone by, so the lengths are counted from phase edges that line up with the strobe.

// File: rtl/pwm_dc_pkg.sv
package pwm_dc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_REST   = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DIV  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_INV_BIT = 1;
    localparam int CTRL_SRC_BIT = 2;
endpackage

// File: rtl/pwm_dc_regs.sv
module pwm_dc_regs
    import pwm_dc_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int TICK_BITS = 8,
    parameter int DIV_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [REG_W-1:0]     wr_data,
    output logic                 run_en,
    output logic                 inv_en,
    output logic                 src_ext,
    output logic [DIV_BITS-1:0]  div_sh,
    output logic [TICK_BITS-1:0] act_sh,
    output logic [TICK_BITS-1:0] rest_sh
);
    localparam int DATA_MSB = 2 * TICK_BITS - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            inv_en  <= 1'b0;
            src_ext <= 1'b0;
            div_sh  <= '0;
            act_sh  <= '0;
            rest_sh <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    run_en  <= wr_data[CTRL_RUN_BIT];
                    inv_en  <= wr_data[CTRL_INV_BIT];
                    src_ext <= wr_data[CTRL_SRC_BIT];
                end
                SEL_DIV:  div_sh <= wr_data[DIV_BITS:1];
                SEL_DATA: begin
                    act_sh  <= wr_data[DATA_MSB:TICK_BITS];
                    rest_sh <= wr_data[TICK_BITS-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_dc_prescaler.sv
module pwm_dc_prescaler #(
    parameter int DIV_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                src_ext,
    input  logic                ext_tick,
    input  logic [DIV_BITS-1:0] div_n,
    output logic                tick
);
    logic [DIV_BITS-1:0] pcnt_q;
    logic                base;

    always_comb begin
        base = src_ext ? ext_tick : 1'b1;
        tick = run && base && (pcnt_q == div_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (!run)
            pcnt_q <= '0;
        else if (base)
            pcnt_q <= (pcnt_q == div_n) ? '0 : pcnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_dc_phase_fsm.sv
module pwm_dc_phase_fsm
    import pwm_dc_pkg::*;
#(
    parameter int TICK_BITS = 8,
    parameter int DIV_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 tick,
    input  logic [DIV_BITS-1:0]  div_sh,
    input  logic [TICK_BITS-1:0] act_sh,
    input  logic [TICK_BITS-1:0] rest_sh,
    output phase_e               state_q,
    output logic [DIV_BITS-1:0]  div_act,
    output logic [TICK_BITS-1:0] act_cnt,
    output logic                 run,
    output logic                 phase_on
);
    phase_e               state_d;
    logic [TICK_BITS-1:0] cnt_q;
    logic [TICK_BITS-1:0] rest_cnt;
    logic                 load;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (run_en) state_d = PH_ACTIVE;
            PH_ACTIVE: if (tick && cnt_q == act_cnt) state_d = PH_REST;
            PH_REST:   if (tick && cnt_q == rest_cnt) state_d = PH_ACTIVE;
            default:   state_d = PH_IDLE;
        endcase
        if (!run_en) state_d = PH_IDLE;
        load = run_en && (state_q == PH_IDLE ||
                          (state_q == PH_REST && state_d == PH_ACTIVE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            div_act  <= '0;
            act_cnt  <= '0;
            rest_cnt <= '0;
        end else begin
            if (state_d != state_q || state_q == PH_IDLE)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + 1'b1;
            if (load) begin
                div_act  <= div_sh;
                act_cnt  <= act_sh;
                rest_cnt <= rest_sh;
            end
        end
    end

    always_comb begin
        run      = (state_q != PH_IDLE);
        phase_on = (state_q == PH_ACTIVE);
    end
endmodule

// File: rtl/pwm_dual_count.sv
module pwm_dual_count
    import pwm_dc_pkg::*;
#(
    parameter int REG_W     = 32,
    parameter int TICK_BITS = 8,
    parameter int DIV_BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ext_tick,
    output logic             pwm_out
);
    logic                 run_en, inv_en, src_ext;
    logic [DIV_BITS-1:0]  div_sh, div_act;
    logic [TICK_BITS-1:0] act_sh, rest_sh, act_cnt;
    logic                 tick, run, phase_on;
    phase_e               state_q;

    pwm_dc_regs #(.REG_W(REG_W), .TICK_BITS(TICK_BITS), .DIV_BITS(DIV_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .run_en(run_en), .inv_en(inv_en), .src_ext(src_ext),
        .div_sh(div_sh), .act_sh(act_sh), .rest_sh(rest_sh)
    );

    pwm_dc_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .src_ext(src_ext),
        .ext_tick(ext_tick), .div_n(div_act), .tick(tick)
    );

    pwm_dc_phase_fsm #(.TICK_BITS(TICK_BITS), .DIV_BITS(DIV_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .div_sh(div_sh), .act_sh(act_sh), .rest_sh(rest_sh),
        .state_q(state_q), .div_act(div_act), .act_cnt(act_cnt),
        .run(run), .phase_on(phase_on)
    );

    always_comb pwm_out = phase_on ^ inv_en;
endmodule

// File: rtl/pwm_dual_count_chk.sv
module pwm_dual_count_chk
    import pwm_dc_pkg::*;
#(
    parameter int TICK_BITS = 8,
    parameter int DIV_BITS  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run_en,
    input logic                 inv_en,
    input logic                 src_ext,
    input logic                 ext_tick,
    input logic                 tick,
    input phase_e               state_q,
    input logic [DIV_BITS-1:0]  div_act,
    input logic [TICK_BITS-1:0] act_cnt,
    input logic                 pwm_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) p_reset_low_r1: assert (pwm_out == 1'b0);
    end

    p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> state_q == PH_IDLE);

    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_IDLE |-> pwm_out == inv_en);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state_q != PH_IDLE && !tick) |=> $stable(state_q));

    p_ext_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && !ext_tick) |-> !tick);

    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_ACTIVE |=> ($stable(act_cnt) && $stable(div_act)));

    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && run_en) |=> state_q == PH_ACTIVE);
endmodule

bind pwm_dual_count pwm_dual_count_chk #(.TICK_BITS(TICK_BITS), .DIV_BITS(DIV_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .inv_en(inv_en), .src_ext(src_ext),
    .ext_tick(ext_tick), .tick(tick), .state_q(state_q), .div_act(div_act),
    .act_cnt(act_cnt), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_dual_count.sv
module tb_pwm_dual_count;
    localparam int REG_W = 32;
    localparam int TB    = 8;
    localparam int NV    = 6;
    // divider word (raw), active-1, rest-1, expected high clocks, expected low clocks
    localparam int V_DIV [NV] = '{0, 0, 4, 5, 0, 2};
    localparam int V_ACT [NV] = '{0, 4, 1, 2, 255, 0};
    localparam int V_RST [NV] = '{0, 2, 3, 0, 0, 6};
    localparam int V_HI  [NV] = '{1, 5, 6, 9, 256, 2};
    localparam int V_LO  [NV] = '{1, 3, 12, 3, 1, 14};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [REG_W-1:0] wr_data = '0;
    logic             ext_tick = 1'b0;
    logic             pwm_out;
    int               total = 0;
    int               bad = 0;
    int               cyc = 0;
    logic             done = 1'b0;

    pwm_dual_count #(.REG_W(REG_W), .TICK_BITS(TB), .DIV_BITS(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_tick(ext_tick), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        ext_tick <= ((cyc % 4) == 3);
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = REG_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_level(input logic lv);
        while (pwm_out !== lv) @(negedge clk);
    endtask

    task automatic count_level(input logic lv, output int n);
        n = 0;
        while (pwm_out === lv) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    task automatic measure(input logic lv, output int a, output int b);
        wait_level(!lv); wait_level(lv);
        wait_level(!lv); wait_level(lv);
        count_level(lv, a);
        count_level(!lv, b);
    endtask

    initial begin
        int hi, lo, hi2, lo2, errs;
        repeat (3) @(negedge clk);
        chk("R1 out in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 out after reset", int'(pwm_out), 0);

        // R9: rise one clock after the run bit is sampled
        wr(2'd1, 0);
        wr(2'd2, (20 << TB) | 3);
        wr(2'd0, 1);
        chk("R9 low before start", int'(pwm_out), 0);
        @(negedge clk);
        chk("R9 high on start", int'(pwm_out), 1);

        // table walk: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 0);
            wr(2'd1, V_DIV[i]);
            wr(2'd2, (V_ACT[i] << TB) | V_RST[i]);
            wr(2'd0, 1);
            measure(1'b1, hi, lo);
            chk($sformatf("R2 R3 R4 vec%0d high", i), hi, V_HI[i]);
            chk($sformatf("R2 R3 R4 vec%0d low", i), lo, V_LO[i]);
        end

        // R5: clearing run stops the output
        wr(2'd0, 0);
        @(negedge clk);
        errs = 0;
        repeat (40) begin
            if (pwm_out !== 1'b0) errs = errs + 1;
            @(negedge clk);
        end
        chk("R5 stopped output samples high", errs, 0);

        // R6: inverter at idle and while running
        wr(2'd0, 2);
        @(negedge clk);
        chk("R6 idle inverted level", int'(pwm_out), 1);
        wr(2'd1, 0);
        wr(2'd2, (2 << TB) | 5);
        wr(2'd0, 3);
        measure(1'b0, lo, hi);
        chk("R6 inverted low length", lo, 3);
        chk("R6 inverted high length", hi, 6);

        // R7: external tick strobe every 4 clocks
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd2, (1 << TB) | 2);
        wr(2'd0, 5);
        measure(1'b1, hi, lo);
        chk("R7 ext high length", hi, 8);
        chk("R7 ext low length", lo, 12);

        // R8: write during active phase waits for period end
        wr(2'd0, 0);
        wr(2'd1, 0);
        wr(2'd2, (9 << TB) | 9);
        wr(2'd0, 1);
        wait_level(1'b0); wait_level(1'b1);
        fork
            begin
                repeat (3) @(negedge clk);
                wr(2'd2, (2 << TB) | 3);
            end
        join_none
        count_level(1'b1, hi);
        count_level(1'b0, lo);
        count_level(1'b1, hi2);
        count_level(1'b0, lo2);
        chk("R8 current high kept", hi, 10);
        chk("R8 current low kept", lo, 10);
        chk("R8 next high new", hi2, 3);
        chk("R8 next low new", lo2, 4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule